// File: doc/BRIEF.md
# Serial Command Register Port

This block is a synchronous serial slave that gives a host access to a small bank of 24-bit control registers. The host selects the port with an active-low chip select and toggles a serial clock. On each rising clock edge it presents one data bit. The block first collects an 8-bit command byte. It then takes one of three actions:

- It runs a system operation by pulsing a strobe that carries an opcode.
- It loads the addressed register into a transmit shifter and sends it back on the serial output.
- It gathers 24 data bits and commits them to the register only after the last bit has arrived.

All serial inputs are brought into the local clock domain through a synchronizer and are oversampled. The serial clock must therefore run several times slower than the local clock. Frames may be chained while chip select stays low: after each transfer the port waits for the next command byte. Raising chip select at any point discards the frame in progress.

Top module: `srp_port`

## Requirements
- R1: After reset, sdo is 0, wr_stb and sys_stb are 0, and every register reads back as zero.
- R2: The command byte is sampled MSB first on rising serial-clock edges, and its encoding is as follows. Bit 7 = 1 selects a system operation with opcode in bits 6:0. Bit 7 = 0 selects a register access: bit 6 = 1 means write and 0 means read, and bits 5:1 are the register address. Bit 0 is ignored.
- R3: A read returns the register value at command decode as 24 bits, MSB first. sdo changes only after falling serial-clock edges, so it is stable while the serial clock is high.
- R4: A write changes the register only after the 24th data bit. At that point wr_stb pulses for exactly one clock cycle, carrying wr_addr and wr_data (MSB first as received).
- R5: A system command pulses sys_stb for one clock cycle with sys_op equal to command bits 6:0, and changes no register.
- R6: Deasserting cs_n mid-frame returns the port to waiting for a command and discards any partial write. The abort also wins when the deassertion and the 24th write clock rise together.
- R7: An address at or above NUM_REGS (8 by default) reads as zero. A write to such an address is ignored and produces no wr_stb, but it still consumes 24 data clocks.
- R8: After a completed read, write or system command, the next 8 bits within the same chip-select period are decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| wr_stb | output | 1 | One-cycle pulse when a register write completes |
| wr_addr | output | 5 | Address of the completed write |
| wr_data | output | DATA_W (24) | Data of the completed write |
| sys_stb | output | 1 | One-cycle pulse for a system command |
| sys_op | output | 7 | Opcode of the system command |

## Verification
Two events can collide in the same local clock cycle: the final rising edge of a write's data phase, and the deassertion of chip select. The bench raises cs_n and sclk at the same instant on the 24th data bit. Both signals pass through identical synchronizer stages, so the port sees them together. The result is judged at the ports: no wr_stb may appear, and a later read must return the old register value. Random frames that mix reads, writes, system commands and out-of-range addresses are also checked against a bench register model.

// File: rtl/srp_pkg.sv
package srp_pkg;
   localparam int CMD_W  = 8;
   localparam int ADDR_W = 5;
   localparam int OP_W   = 7;

   typedef enum logic [1:0] {
      ST_CMD = 2'd0,
      ST_RD  = 2'd1,
      ST_WR  = 2'd2
   } srp_state_e;

   typedef struct packed {
      logic              sys;
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [OP_W-1:0]   op;
   } srp_cmd_t;

   function automatic srp_cmd_t srp_decode(input logic [CMD_W-1:0] b);
      srp_cmd_t c;
      c.sys  = b[7];
      c.wr   = b[6];
      c.addr = b[5:1];
      c.op   = b[6:0];
      return c;
   endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srp_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
   parameter int DATA_W   = 24,
   parameter int NUM_REGS = 8,
   parameter int ADDR_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                                  regs[i] <= '0;
            else if (we && waddr == ADDR_W'(i))          regs[i] <= wdata;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (raddr == ADDR_W'(i)) rdata = regs[i];
   end
endmodule

// File: rtl/srp_port.sv
module srp_port
   import srp_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int NUM_REGS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk,
   input  logic                cs_n,
   input  logic                sdi,
   output logic                sdo,
   output logic                wr_stb,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                sys_stb,
   output logic [OP_W-1:0]     sys_op
);
   localparam int CNT_MAX = (DATA_W > CMD_W) ? DATA_W : CMD_W;
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < CMD_W) begin : g_bad_width
         $error("srp_port: DATA_W must be at least CMD_W");
      end
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
         $error("srp_port: NUM_REGS out of range");
      end
   endgenerate

   logic [2:0] sync_q;
   logic       s_cs_n, s_sclk, s_sdi, sclk_d;
   logic       sclk_rise, sclk_fall, cs_hi;

   srp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(sync_q)
   );
   assign {s_cs_n, s_sclk, s_sdi} = sync_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= s_sclk;

   assign sclk_rise = s_sclk & ~sclk_d;
   assign sclk_fall = ~s_sclk & sclk_d;
   assign cs_hi     = s_cs_n;

   srp_state_e          state;
   logic [CNT_W-1:0]    cnt;
   logic [DATA_W-1:0]   rx_sr, tx_sr, word_now, rd_data;
   logic [ADDR_W-1:0]   addr_q;
   srp_cmd_t            cmd_now;

   assign word_now = {rx_sr[DATA_W-2:0], s_sdi};
   assign cmd_now  = srp_decode(word_now[CMD_W-1:0]);

   srp_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(wr_stb), .waddr(wr_addr), .wdata(wr_data),
      .raddr(cmd_now.addr), .rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_CMD;
         cnt     <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
         addr_q  <= '0;
         sdo     <= 1'b0;
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         sys_stb <= 1'b0;
         sys_op  <= '0;
      end else begin
         wr_stb  <= 1'b0;
         sys_stb <= 1'b0;
         if (cs_hi) begin
            state <= ST_CMD;
            cnt   <= '0;
            sdo   <= 1'b0;
         end else if (sclk_rise) begin
            rx_sr <= word_now;
            cnt   <= cnt + 1'b1;
            unique case (state)
               ST_CMD: if (cnt == CMD_LAST) begin
                  cnt <= '0;
                  if (cmd_now.sys) begin
                     sys_stb <= 1'b1;
                     sys_op  <= cmd_now.op;
                  end else begin
                     addr_q <= cmd_now.addr;
                     tx_sr  <= rd_data;
                     state  <= cmd_now.wr ? ST_WR : ST_RD;
                  end
               end
               ST_WR: if (cnt == DATA_LAST) begin
                  cnt   <= '0;
                  state <= ST_CMD;
                  if (int'(addr_q) < NUM_REGS) begin
                     wr_stb  <= 1'b1;
                     wr_addr <= addr_q;
                     wr_data <= word_now;
                  end
               end
               ST_RD: if (cnt == DATA_LAST) begin
                  cnt   <= '0;
                  state <= ST_CMD;
               end
               default: state <= ST_CMD;
            endcase
         end else if (sclk_fall) begin
            if (state == ST_RD) begin
               sdo   <= tx_sr[DATA_W-1];
               tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end else begin
               sdo <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/srp_chk.sv
module srp_chk #(
   parameter int NUM_REGS = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sdo,
   input logic       wr_stb,
   input logic [4:0] wr_addr,
   input logic       sys_stb,
   input logic       sclk_fall,
   input logic       cs_hi
);
   // R3
   sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> ($past(sclk_fall) || $past(cs_hi)));
   // R4
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   // R5
   sys_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_stb |=> !sys_stb);
   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && sys_stb));
   // R6
   abort_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !$past(cs_hi));
   // R7
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (int'(wr_addr) < NUM_REGS));
endmodule

bind srp_port srp_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .sdo(sdo), .wr_stb(wr_stb), .wr_addr(wr_addr),
   .sys_stb(sys_stb), .sclk_fall(sclk_fall), .cs_hi(cs_hi)
);

// File: tb/tb_srp_port.sv
module tb_srp_port;
   localparam int HALF = 8;
   localparam int NREG = 8;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
   logic        sdo, wr_stb, sys_stb;
   logic [4:0]  wr_addr;
   logic [23:0] wr_data;
   logic [6:0]  sys_op;

   srp_port dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .sys_stb(sys_stb), .sys_op(sys_op)
   );

   always #10 clk = ~clk;

   int checks = 0, fails = 0, unstable = 0;
   int wr_cnt = 0, sys_cnt = 0;
   logic [4:0]  last_waddr;
   logic [23:0] last_wdata;
   logic [6:0]  last_op;
   logic [23:0] model [NREG];
   bit          done = 0;

   always @(posedge clk) begin
      if (wr_stb)  begin wr_cnt++; last_waddr <= wr_addr; last_wdata <= wr_data; end
      if (sys_stb) begin sys_cnt++; last_op <= sys_op; end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_read(input logic [4:0] a);
      return (int'(a) < NREG) ? model[a] : 24'h0;
   endfunction

   task automatic bit_io(input logic b, input bit abort, output logic o);
      sdi = b;
      repeat (HALF) @(negedge clk);
      o = sdo;
      sclk = 1'b1;
      if (abort) cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!abort && sdo !== o) unstable++;
      sclk = 1'b0;
   endtask

   task automatic frame_open();
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic frame_close();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic send_cmd(input logic [7:0] c);
      logic o;
      for (int i = 7; i >= 0; i--) bit_io(c[i], 1'b0, o);
   endtask

   task automatic xfer24(input logic [23:0] din, input int abort_at, output logic [23:0] dout);
      logic o;
      dout = '0;
      for (int i = 0; i < 24; i++) begin
         bit_io(din[23-i], i == abort_at, o);
         dout[23-i] = o;
         if (i == abort_at) break;
      end
   endtask

   function automatic logic [7:0] c_rd(input logic [4:0] a, input logic lsb);
      return {2'b00, a, lsb};
   endfunction
   function automatic logic [7:0] c_wr(input logic [4:0] a, input logic lsb);
      return {2'b01, a, lsb};
   endfunction

   task automatic op_read(input logic [4:0] a, input string req);
      logic [23:0] d;
      logic [23:0] e;
      e = exp_read(a);
      send_cmd(c_rd(a, 1'($urandom)));
      xfer24(24'h0, -1, d);
      chk(d === e, req, {8'h0, d}, {8'h0, e});
   endtask

   task automatic op_write(input logic [4:0] a, input logic [23:0] v);
      logic [23:0] d;
      send_cmd(c_wr(a, 1'($urandom)));
      xfer24(v, -1, d);
      if (int'(a) < NREG) model[a] = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int w0, s0;
      logic [23:0] d;
      logic [6:0]  op;
      void'($urandom(32'h5A17));
      for (int i = 0; i < NREG; i++) model[i] = '0;
      repeat (5) @(negedge clk);
      // R1 reset state at the ports
      chk(sdo === 1'b0 && wr_stb === 1'b0 && sys_stb === 1'b0, "R1",
          {29'h0, sdo, wr_stb, sys_stb}, 32'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 register reads as zero after reset
      frame_open(); op_read(5'd5, "R1"); frame_close();

      // R4 write then read back; strobe carries address and data
      w0 = wr_cnt;
      frame_open(); op_write(5'd3, 24'hA5C3_0F); frame_close();
      chk(wr_cnt == w0 + 1, "R4", wr_cnt, w0 + 1);
      chk(last_waddr == 5'd3 && last_wdata == 24'hA5C30F, "R4",
          {3'h0, last_waddr, last_wdata}, {8'h03, 24'hA5C30F});
      frame_open(); op_read(5'd3, "R3"); frame_close();

      // R5 system command: strobe with opcode, registers untouched
      s0 = sys_cnt;
      frame_open(); send_cmd(8'hC9); frame_close();
      chk(sys_cnt == s0 + 1 && last_op == 7'h49, "R5", {sys_cnt[7:0], 1'b0, last_op}, {8'(s0 + 1), 8'h49});
      frame_open(); op_read(5'd3, "R5"); frame_close();

      // R6 abort after 10 data bits: no strobe, register unchanged
      w0 = wr_cnt;
      frame_open(); send_cmd(c_wr(5'd3, 1'b0)); xfer24(24'h123456, 9, d); frame_close();
      chk(wr_cnt == w0, "R6", wr_cnt, w0);
      frame_open(); op_read(5'd3, "R6"); frame_close();

      // R6 cs_n rises together with the 24th write clock
      w0 = wr_cnt;
      frame_open(); send_cmd(c_wr(5'd3, 1'b1)); xfer24(24'hFFFFFF, 23, d); frame_close();
      chk(wr_cnt == w0, "R6", wr_cnt, w0);
      frame_open(); op_read(5'd3, "R6"); frame_close();

      // R7 out-of-range write ignored, clocks consumed; R8 chained command
      w0 = wr_cnt;
      frame_open(); op_write(5'd20, 24'hBEEF01); op_read(5'd3, "R7"); frame_close();
      chk(wr_cnt == w0, "R7", wr_cnt, w0);
      frame_open(); op_read(5'd20, "R7"); frame_close();

      // R8 write, system command and read in one frame
      s0 = sys_cnt;
      frame_open(); op_write(5'd7, 24'h800001); send_cmd(8'h80); op_read(5'd7, "R8"); frame_close();
      chk(sys_cnt == s0 + 1 && last_op == 7'h00, "R8", sys_cnt, s0 + 1);

      // R2 bit 0 of the command is ignored
      frame_open(); send_cmd(c_rd(5'd7, 1'b1)); xfer24(24'h0, -1, d); frame_close();
      chk(d === 24'h800001, "R2", {8'h0, d}, 32'h800001);

      // Random mix
      for (int n = 0; n < 60; n++) begin
         int nops;
         nops = 1 + ($urandom % 3);
         frame_open();
         for (int k = 0; k < nops; k++) begin
            int kind;
            logic [4:0]  a;
            logic [23:0] v;
            kind = $urandom % 3;
            a = 5'($urandom % 12);
            v = 24'($urandom);
            if (kind == 0) begin
               w0 = wr_cnt;
               op_write(a, v);
               repeat (HALF) @(negedge clk);
               chk(wr_cnt == w0 + ((int'(a) < NREG) ? 1 : 0), "R4", wr_cnt, w0);
            end else if (kind == 1) begin
               op_read(a, "R3");
            end else begin
               s0 = sys_cnt;
               op = 7'($urandom);
               send_cmd({1'b1, op});
               repeat (HALF) @(negedge clk);
               chk(sys_cnt == s0 + 1 && last_op == op, "R5", {25'h0, last_op}, {25'h0, op});
            end
         end
         frame_close();
      end

      // R3 sdo never moved while sclk was high
      chk(unstable == 0, "R3", unstable, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule